// File: doc/BRIEF.md
# SCSI DMA Byte-Transfer Sequencer

This block moves bytes one at a time between a host DMA controller and a SCSI data path. When DMA is enabled and one of three start strobes is accepted, it takes one of four roles: send as target, send as initiator, receive as target, or receive as initiator. The role is fixed at start. From then on it runs the SCSI request/acknowledge handshake on its own. Each byte passes through a one-byte holding register, which is loaded either from the host write bus or from the SCSI data bus.

Two host handshake styles are supported. In the interlocked style, DRQ asks for one byte and the rising edge of the active-low acknowledge ends that byte. In the burst style, DRQ stays high for the whole transfer and the acknowledge may stay low throughout. The rising edge of the read or write strobe ends each byte, and READY paces the next one. An end-of-process input can raise an interrupt. It never stops the transfer. Clearing the DMA enable is the only way to stop one.

Top module: `dma_xfer_seq`

## Requirements
- R1: After synchronous reset, drq, ready, irq, cfg_err, scsi_req_o, scsi_ack_o and scsi_data_oe are all 0.
- R2: While cfg_dma_en is 0, every start strobe is ignored. A send start with cfg_drive_bus at 0 is also ignored. An ignored start leaves drq and scsi_req_o at 0 and does not set cfg_err.
- R3: A target-receive start with cfg_target=0, or an initiator-receive start with cfg_target=1, is ignored and sets cfg_err (only while DMA is enabled). cfg_err stays set until reset.
- R4: Receive as target: scsi_req_o rises in the cycle after the start. When scsi_ack_i is seen high, scsi_data_i is latched onto host_rdata and scsi_req_o falls. When scsi_ack_i is seen low again, the byte is offered to the host.
- R5: Receive as initiator: scsi_ack_o stays 0 until scsi_req_i is seen high. It then rises with the byte latched onto host_rdata, and falls once scsi_req_i is seen low. After that the byte is offered to the host.
- R6: Interlocked style (cfg_block=0): drq is high only while a host byte is pending. A strobe edge does not end the byte. drq falls in the cycle after dack_n rises.
- R7: Burst style (cfg_block=1): drq stays high for the whole active transfer, and ready is high only while a host byte is pending. A byte ends when the strobe for the direction (ior_n on receive, iow_n on send) rises while dack_n is low.
- R8: Send as target: a send start raises drq at once. The byte written while iow_n and dack_n are both low is driven on scsi_data_o with scsi_data_oe=1 and scsi_req_o=1. In interlocked style, drq stays 0 until scsi_ack_i has gone high and then low.
- R9: Send as initiator: after the host byte, scsi_data_oe=1 with the byte on scsi_data_o. scsi_ack_o rises only once scsi_req_i is seen high, and falls after scsi_req_i goes low.
- R10: Clearing cfg_dma_en returns the block to idle in the next cycle, with drq, ready, scsi_req_o, scsi_ack_o and scsi_data_oe all 0.
- R11: A falling edge on eop_n sets irq when cfg_eop_irq_en=1, and does nothing when it is 0. The transfer in progress continues. An accepted start clears irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dma_en | input | 1 | DMA enable; 0 stops any transfer |
| cfg_block | input | 1 | 1 selects burst host handshake |
| cfg_target | input | 1 | 1 = target role, 0 = initiator role |
| cfg_drive_bus | input | 1 | Data bus drive enable, required for send |
| cfg_eop_irq_en | input | 1 | Enables interrupt on end-of-process |
| start_send | input | 1 | Start-send write strobe |
| start_trecv | input | 1 | Start target-receive write strobe |
| start_irecv | input | 1 | Start initiator-receive write strobe |
| dack_n | input | 1 | Host DMA acknowledge, active low |
| ior_n | input | 1 | Host read strobe, active low |
| iow_n | input | 1 | Host write strobe, active low |
| eop_n | input | 1 | End of process, active low |
| host_wdata | input | DW | Host byte for send |
| host_rdata | output | DW | Byte latched from SCSI for receive |
| drq | output | 1 | DMA request |
| ready | output | 1 | Burst-style pacing |
| irq | output | 1 | End-of-process interrupt |
| cfg_err | output | 1 | Sticky role-mismatch flag |
| scsi_req_i | input | 1 | SCSI REQ seen on bus (asserted = 1) |
| scsi_ack_i | input | 1 | SCSI ACK seen on bus (asserted = 1) |
| scsi_data_i | input | DW | SCSI data seen on bus |
| scsi_req_o | output | 1 | REQ drive (target role) |
| scsi_ack_o | output | 1 | ACK drive (initiator role) |
| scsi_data_o | output | DW | SCSI data to drive |
| scsi_data_oe | output | 1 | SCSI data drive enable |

## Verification
A wrong sequencer state shows at the ports within one clock. The outputs are decoded directly from the state register. A stuck or skipped phase therefore shows up as a missing or early scsi_req_o, scsi_ack_o or drq in the very next sampled cycle. A wrong latch shows up as a wrong host_rdata or scsi_data_o in the same cycle that the handshake advances. A lost role or direction bit drives the wrong handshake line, or leaves scsi_data_oe wrong, as soon as the first SCSI phase is entered.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOST = 2'd1,
    ST_PH1  = 2'd2,
    ST_PH2  = 2'd3
  } xfer_st_e;
endpackage

// File: rtl/dxs_edge_det.sv
module dxs_edge_det #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_n,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= sig_n;
  end

  // Active-low inputs: a rise is the end of an assertion.
  assign rise = ~prev_q & sig_n;
  assign fall = prev_q & ~sig_n;
endmodule

// File: rtl/dxs_start_gate.sv
module dxs_start_gate (
  input  logic dma_en,
  input  logic target,
  input  logic drive_bus,
  input  logic busy,
  input  logic start_send,
  input  logic start_trecv,
  input  logic start_irecv,
  output logic go,
  output logic go_send,
  output logic go_target,
  output logic err_set
);
  logic ok_send, ok_trecv, ok_irecv;

  always_comb begin
    ok_send  = start_send  && dma_en && drive_bus && !busy;
    ok_trecv = start_trecv && dma_en && target    && !busy;
    ok_irecv = start_irecv && dma_en && !target   && !busy;
    go        = ok_send || ok_trecv || ok_irecv;
    go_send   = ok_send;
    go_target = target;
    err_set   = dma_en && ((start_trecv && !target) || (start_irecv && target));
  end
endmodule

// File: rtl/dxs_fsm.sv
module dxs_fsm
  import dxs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_en,
  input  logic          go,
  input  logic          go_send,
  input  logic          go_target,
  input  logic          byte_end,
  input  logic          host_wr_low,
  input  logic [DW-1:0] host_wdata,
  input  logic          scsi_req_i,
  input  logic          scsi_ack_i,
  input  logic [DW-1:0] scsi_data_i,
  output xfer_st_e      state,
  output logic          is_send,
  output logic          is_target,
  output logic [DW-1:0] hold
);
  xfer_st_e      st_q, st_d;
  logic          send_q, tgt_q;
  logic [DW-1:0] hold_q;
  logic          peer_hi;

  // Target waits on ACK from the initiator, initiator waits on REQ.
  assign peer_hi = tgt_q ? scsi_ack_i : scsi_req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go) st_d = go_send ? ST_HOST : ST_PH1;
      ST_HOST: if (byte_end) st_d = ST_PH1;
      ST_PH1:  if (peer_hi) st_d = ST_PH2;
      ST_PH2:  if (!peer_hi) st_d = ST_HOST;
      default: st_d = ST_IDLE;
    endcase
    if (!dma_en) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      send_q <= 1'b0;
      tgt_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && go) begin
        send_q <= go_send;
        tgt_q  <= go_target;
      end
      if (send_q && st_q == ST_HOST && host_wr_low)
        hold_q <= host_wdata;
      else if (!send_q && st_q == ST_PH1 && peer_hi && dma_en)
        hold_q <= scsi_data_i;
    end
  end

  assign state     = st_q;
  assign is_send   = send_q;
  assign is_target = tgt_q;
  assign hold      = hold_q;
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dxs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_dma_en,
  input  logic          cfg_block,
  input  logic          cfg_target,
  input  logic          cfg_drive_bus,
  input  logic          cfg_eop_irq_en,
  input  logic          start_send,
  input  logic          start_trecv,
  input  logic          start_irecv,
  input  logic          dack_n,
  input  logic          ior_n,
  input  logic          iow_n,
  input  logic          eop_n,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          drq,
  output logic          ready,
  output logic          irq,
  output logic          cfg_err,
  input  logic          scsi_req_i,
  input  logic          scsi_ack_i,
  input  logic [DW-1:0] scsi_data_i,
  output logic          scsi_req_o,
  output logic          scsi_ack_o,
  output logic [DW-1:0] scsi_data_o,
  output logic          scsi_data_oe
);
  localparam int NE = 4;
  localparam int E_DACK = 0;
  localparam int E_IOR  = 1;
  localparam int E_IOW  = 2;
  localparam int E_EOP  = 3;

  logic [NE-1:0] rise, fall;
  logic          go, go_send, go_target, err_set;
  logic          busy, byte_end, strobe_rise, host_wr_low;
  xfer_st_e      state;
  logic          is_send, is_target;
  logic [DW-1:0] hold;
  logic          irq_q, err_q;

  dxs_edge_det #(.N(NE)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .sig_n({eop_n, iow_n, ior_n, dack_n}),
    .rise (rise),
    .fall (fall)
  );

  assign busy = (state != ST_IDLE);

  dxs_start_gate u_gate (
    .dma_en     (cfg_dma_en),
    .target     (cfg_target),
    .drive_bus  (cfg_drive_bus),
    .busy       (busy),
    .start_send (start_send),
    .start_trecv(start_trecv),
    .start_irecv(start_irecv),
    .go         (go),
    .go_send    (go_send),
    .go_target  (go_target),
    .err_set    (err_set)
  );

  assign strobe_rise = is_send ? rise[E_IOW] : rise[E_IOR];
  assign byte_end    = cfg_block ? (strobe_rise && !dack_n) : rise[E_DACK];
  assign host_wr_low = !iow_n && !dack_n;

  dxs_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .dma_en     (cfg_dma_en),
    .go         (go),
    .go_send    (go_send),
    .go_target  (go_target),
    .byte_end   (byte_end),
    .host_wr_low(host_wr_low),
    .host_wdata (host_wdata),
    .scsi_req_i (scsi_req_i),
    .scsi_ack_i (scsi_ack_i),
    .scsi_data_i(scsi_data_i),
    .state      (state),
    .is_send    (is_send),
    .is_target  (is_target),
    .hold       (hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (go)                                   irq_q <= 1'b0;
      else if (fall[E_EOP] && cfg_eop_irq_en)   irq_q <= 1'b1;
      if (err_set) err_q <= 1'b1;
    end
  end

  // Moore decode from the state flops.
  assign drq          = cfg_block ? busy : (state == ST_HOST);
  assign ready        = cfg_block && (state == ST_HOST);
  assign scsi_req_o   = is_target && (state == ST_PH1);
  assign scsi_ack_o   = !is_target && (state == ST_PH2);
  assign scsi_data_oe = is_send && (state == ST_PH1 || state == ST_PH2);
  assign scsi_data_o  = hold;
  assign host_rdata   = hold;
  assign irq          = irq_q;
  assign cfg_err      = err_q;
endmodule

// File: rtl/dxs_chk.sv
module dxs_chk (
  input logic clk,
  input logic rst,
  input logic cfg_dma_en,
  input logic cfg_block,
  input logic dack_n,
  input logic drq,
  input logic ready,
  input logic cfg_err,
  input logic scsi_req_o,
  input logic scsi_ack_o,
  input logic scsi_data_oe
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !cfg_dma_en |=> (!drq && !scsi_req_o && !scsi_ack_o && !scsi_data_oe)); // R10

  AST_ROLE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(scsi_req_o && scsi_ack_o)); // R4

  AST_NORMAL_BYTE_END: assert property (@(posedge clk) disable iff (rst)
    (!cfg_block && cfg_dma_en && drq && dack_n && !$past(dack_n)) |=> !drq); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R3

  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    ready |-> (drq && cfg_block)); // R7

  AST_NO_DRQ_DURING_REQ: assert property (@(posedge clk) disable iff (rst)
    (scsi_req_o && !cfg_block) |-> !drq); // R8
endmodule

bind dma_xfer_seq dxs_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_dma_en  (cfg_dma_en),
  .cfg_block   (cfg_block),
  .dack_n      (dack_n),
  .drq         (drq),
  .ready       (ready),
  .cfg_err     (cfg_err),
  .scsi_req_o  (scsi_req_o),
  .scsi_ack_o  (scsi_ack_o),
  .scsi_data_oe(scsi_data_oe)
);

// File: tb/tb_dma_xfer_seq.sv
module tb_dma_xfer_seq;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_dma_en = 0, cfg_block = 0, cfg_target = 0, cfg_drive_bus = 0, cfg_eop_irq_en = 0;
  logic start_send = 0, start_trecv = 0, start_irecv = 0;
  logic dack_n = 1, ior_n = 1, iow_n = 1, eop_n = 1;
  logic [DW-1:0] host_wdata = '0, scsi_data_i = '0;
  logic scsi_req_i = 0, scsi_ack_i = 0;
  logic [DW-1:0] host_rdata, scsi_data_o;
  logic drq, ready, irq, cfg_err, scsi_req_o, scsi_ack_o, scsi_data_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_xfer_seq #(.DW(DW)) dut (.*);

  // [7]dma [6]target [5]drive [4:3]start 1=send 2=trecv 3=irecv
  // [2]exp scsi_req_o [1]exp drq [0]exp cfg_err
  localparam logic [7:0] VEC [8] = '{
    8'b0111_0000, 8'b1111_0100, 8'b1011_0001, 8'b1111_1001,
    8'b1011_1000, 8'b1010_1010, 8'b1000_1000, 8'b0111_1000
  };

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    {cfg_dma_en, cfg_block, cfg_target, cfg_drive_bus, cfg_eop_irq_en} = '0;
    {start_send, start_trecv, start_irecv} = '0;
    {dack_n, ior_n, iow_n, eop_n} = 4'hF;
    scsi_req_i = 0; scsi_ack_i = 0;
    step(2);
    rst = 0;
    step();
  endtask

  task automatic pulse_start(int which);
    start_send  = (which == 1);
    start_trecv = (which == 2);
    start_irecv = (which == 3);
    step();
    {start_send, start_trecv, start_irecv} = '0;
  endtask

  task automatic host_write(logic [DW-1:0] d);
    dack_n = 0; iow_n = 0; host_wdata = d; step();
    iow_n = 1; step();
    dack_n = 1; step();
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 outputs", {drq, ready, irq, cfg_err, scsi_req_o, scsi_ack_o, scsi_data_oe}, 0);

    // R2 / R3 start gating table
    for (int v = 0; v < 8; v++) begin
      do_reset();
      cfg_dma_en = VEC[v][7]; cfg_target = VEC[v][6]; cfg_drive_bus = VEC[v][5];
      step();
      pulse_start(int'(VEC[v][4:3]));
      chk($sformatf("R2/R3 vec%0d req", v), scsi_req_o, VEC[v][2]);
      chk($sformatf("R2/R3 vec%0d drq", v), drq, VEC[v][1]);
      chk($sformatf("R3 vec%0d err", v), cfg_err, VEC[v][0]);
    end

    // R3 sticky after a later valid start
    do_reset();
    cfg_dma_en = 1; cfg_target = 0; step();
    pulse_start(2);
    pulse_start(3);
    step();
    chk("R3 err sticky", cfg_err, 1);

    // R4 target receive, R6 interlocked byte end
    do_reset();
    cfg_dma_en = 1; cfg_target = 1; step();
    pulse_start(2);
    chk("R4 req up", scsi_req_o, 1);
    scsi_ack_i = 1; scsi_data_i = 8'hA5; step();
    chk("R4 req down", scsi_req_o, 0);
    chk("R4 rdata", host_rdata, 8'hA5);
    chk("R4 drq still low", drq, 0);
    scsi_ack_i = 0; step();
    chk("R4 drq offered", drq, 1);
    dack_n = 0; step(); ior_n = 0; step(); ior_n = 1; step();
    chk("R6 strobe no end", drq, 1);
    dack_n = 1; step();
    chk("R6 drq falls", drq, 0);
    chk("R6 next req", scsi_req_o, 1);

    // R5 initiator receive
    do_reset();
    cfg_dma_en = 1; cfg_target = 0; step();
    pulse_start(3);
    step();
    chk("R5 ack waits", scsi_ack_o, 0);
    scsi_req_i = 1; scsi_data_i = 8'h3C; step();
    chk("R5 ack up", scsi_ack_o, 1);
    chk("R5 rdata", host_rdata, 8'h3C);
    scsi_req_i = 0; step();
    chk("R5 ack down", scsi_ack_o, 0);
    chk("R5 drq", drq, 1);

    // R8 target send
    do_reset();
    cfg_dma_en = 1; cfg_target = 1; cfg_drive_bus = 1; step();
    pulse_start(1);
    chk("R8 drq at start", drq, 1);
    host_write(8'h5A);
    chk("R8 req", scsi_req_o, 1);
    chk("R8 oe", scsi_data_oe, 1);
    chk("R8 data", scsi_data_o, 8'h5A);
    chk("R8 drq low", drq, 0);
    scsi_ack_i = 1; step();
    chk("R8 req released", scsi_req_o, 0);
    chk("R8 drq wait release", drq, 0);
    scsi_ack_i = 0; step();
    chk("R8 drq again", drq, 1);

    // R9 initiator send
    do_reset();
    cfg_dma_en = 1; cfg_target = 0; cfg_drive_bus = 1; step();
    pulse_start(1);
    host_write(8'hC3);
    chk("R9 oe", scsi_data_oe, 1);
    chk("R9 no ack", scsi_ack_o, 0);
    scsi_req_i = 1; step();
    chk("R9 ack", scsi_ack_o, 1);
    chk("R9 data", scsi_data_o, 8'hC3);
    scsi_req_i = 0; step();
    chk("R9 ack down", scsi_ack_o, 0);

    // R7 burst receive as target, R11 eop with irq enabled
    do_reset();
    cfg_dma_en = 1; cfg_target = 1; cfg_block = 1; cfg_eop_irq_en = 1; step();
    pulse_start(2);
    chk("R7 drq whole", drq, 1);
    chk("R7 ready low", ready, 0);
    scsi_ack_i = 1; scsi_data_i = 8'h81; step();
    scsi_ack_i = 0; step();
    chk("R7 ready", ready, 1);
    dack_n = 0; ior_n = 0; step(); ior_n = 1; step();
    chk("R7 ready drop", ready, 0);
    chk("R7 drq held", drq, 1);
    chk("R7 next req", scsi_req_o, 1);
    eop_n = 0; step();
    chk("R11 irq set", irq, 1);
    chk("R11 still running", scsi_req_o, 1);
    eop_n = 1;
    scsi_ack_i = 1; scsi_data_i = 8'h42; step();
    scsi_ack_i = 0; step();
    chk("R7 second byte", host_rdata, 8'h42);
    chk("R7 ready again", ready, 1);

    // R10 stop by clearing enable
    cfg_dma_en = 0; step();
    chk("R10 idle", {drq, ready, scsi_req_o, scsi_ack_o, scsi_data_oe}, 0);

    // R11 clear on accepted start
    cfg_dma_en = 1; step();
    pulse_start(2);
    chk("R11 irq cleared", irq, 0);

    // R11 eop without enable
    do_reset();
    cfg_dma_en = 1; cfg_target = 1; step();
    pulse_start(2);
    eop_n = 0; step(); eop_n = 1; step();
    chk("R11 no irq", irq, 0);
    chk("R11 transfer kept", scsi_req_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule